// File: doc/BRIEF.md
# 64b/66b Block to XGMII Lane Decoder

This block takes one descrambled 64b/66b block, a 2-bit sync header plus a 64-bit payload, and turns it into eight XGMII byte lanes, each with its own control flag. Data blocks pass straight through. Control blocks are decoded from their block-type byte. The supported formats are all-control, start at lane 0 or lane 4, ordered set at lane 0 or lane 4 (alone, with a start, or paired), and terminate at any lane from 0 to 7. The 7-bit control codes in the payload are turned back into 8-bit XGMII characters.

The decoder sits in a receive path after lock and descrambling. A qualifier input marks the cycles that carry a block. The decoded lanes are registered, so they appear one clock after the block is presented. In cycles with no block the outputs hold their last value.

Top module: `dec66_xgmii_dec`

## Requirements
- R1: With header 01 (data), the eight payload bytes appear unchanged on the output lanes. Lane i carries payload bits [8i+7:8i], and all eight control flags are 0.
- R2: With header 10 and block type 0x1E, every lane is a control character with its flag set. Lane i is decoded from the 7-bit code at payload bits [8+7i+6:8+7i]. Code 0x00 gives Idle 0x07. Code 0x1E, and every other code, gives Error 0xFE.
- R3: Block type 0x78 puts Start (0xFB) on lane 0 with flag set, and payload bytes 1 to 7 as data on lanes 1 to 7. Control flags are 8'h01.
- R4: Block type 0x33 puts the decoded control codes on lanes 0 to 3, Start on lane 4, and payload bytes 5 to 7 as data on lanes 5 to 7. Control flags are 8'h1F.
- R5: Block type 0x4B puts an ordered-set character on lane 0, payload bytes 1 to 3 as data on lanes 1 to 3, and the decoded control codes on lanes 4 to 7. Control flags are 8'hF1. Block type 0x2D puts the control codes on lanes 0 to 3, an ordered-set character on lane 4, and bytes 5 to 7 as data. Control flags are 8'h1F. The lane-0 O code is payload bits [35:32] and the lane-4 O code is bits [39:36]. O code 0x0 gives 0x9C, 0xF gives 0x5C, and any other value gives 0xFE.
- R6: Block type 0x66 puts an ordered set on lane 0 and Start on lane 4. Block type 0x55 puts ordered sets on lanes 0 and 4. For both, lanes 1 to 3 and 5 to 7 carry payload bytes 1 to 3 and 5 to 7 as data, and the control flags are 8'h11.
- R7: A terminate block for lane k uses block type 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for k = 0 to 7. It outputs payload bytes 1 to k as data on lanes 0 to k-1, Terminate (0xFD) on lane k, and decoded control codes on lanes k+1 to 7. Flags are set from lane k upward.
- R8: A header of 00 or 11 drives Error 0xFE on all eight lanes with all flags set.
- R9: A control header with a block type not listed above drives Error 0xFE on all eight lanes with all flags set.
- R10: The output valid is the block-valid input delayed by one clock. Lanes and flags change only one clock after a cycle with block-valid high, and otherwise hold.
- R11: During reset the output valid is 0, every lane is Idle 0x07, and every control flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid_i | input | 1 | Marks a cycle that carries a block |
| blk_hdr_i | input | 2 | Sync header of the block |
| blk_pld_i | input | 64 | Descrambled block payload |
| xg_data_o | output | 64 | Decoded lanes, lane i in bits [8i+7:8i] |
| xg_ctrl_o | output | 8 | Control flag per lane |
| xg_valid_o | output | 1 | Output lanes updated this cycle |

## Verification
Directed blocks cover each block type once, with O codes and control codes chosen so that each mapping branch is reached: 0x0 versus 0xF versus another O value, and Idle versus Error versus an unlisted code. These blocks show whether the right lanes take data, code or special characters. A sweep over all eight terminate types tells apart an off-by-one between the data span and the Terminate lane. Random blocks draw headers and block types from the valid set plus arbitrary bytes, with code fields biased toward 0x00 and 0x1E. They are compared with a byte-level reference, which catches swapped nibbles or a misplaced 7-bit code offset. Idle cycles with changing inputs separate correct holding from updates on every clock.

// File: rtl/dec66_pkg.sv
package dec66_pkg;

   localparam logic [1:0] SH_DATA = 2'b01;
   localparam logic [1:0] SH_CTRL = 2'b10;

   localparam logic [7:0] BT_ALL_CTRL = 8'h1E;
   localparam logic [7:0] BT_C_OS4    = 8'h2D;
   localparam logic [7:0] BT_C_ST4    = 8'h33;
   localparam logic [7:0] BT_OS_ST4   = 8'h66;
   localparam logic [7:0] BT_OS_OS    = 8'h55;
   localparam logic [7:0] BT_ST0      = 8'h78;
   localparam logic [7:0] BT_OS_C     = 8'h4B;

   localparam logic [7:0] XC_IDLE  = 8'h07;
   localparam logic [7:0] XC_START = 8'hFB;
   localparam logic [7:0] XC_TERM  = 8'hFD;
   localparam logic [7:0] XC_ERR   = 8'hFE;
   localparam logic [7:0] XC_SEQ   = 8'h9C;
   localparam logic [7:0] XC_SIG   = 8'h5C;

   localparam logic [6:0] CC_IDLE = 7'h00;
   localparam logic [6:0] CC_ERR  = 7'h1E;

   localparam logic [3:0] OC_SEQ = 4'h0;
   localparam logic [3:0] OC_SIG = 4'hF;

   typedef struct packed {
      logic       hit;
      logic [2:0] lane;
   } term_t;

   function automatic term_t term_lookup(input logic [7:0] bt);
      term_t t;
      t.hit  = 1'b1;
      t.lane = 3'd0;
      case (bt)
         8'h87: t.lane = 3'd0;
         8'h99: t.lane = 3'd1;
         8'hAA: t.lane = 3'd2;
         8'hB4: t.lane = 3'd3;
         8'hCC: t.lane = 3'd4;
         8'hD2: t.lane = 3'd5;
         8'hE1: t.lane = 3'd6;
         8'hFF: t.lane = 3'd7;
         default: t.hit = 1'b0;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/dec66_cmap.sv
module dec66_cmap #(
   parameter int LANE_CNT = 8,
   parameter int LANE_W   = 8,
   parameter int CODE_W   = 7,
   localparam int DATA_W  = LANE_CNT * LANE_W
) (
   input  logic [DATA_W-1:0] pld_i,
   output logic [DATA_W-1:0] chars_o
);
   import dec66_pkg::*;

   if (LANE_W + LANE_CNT * CODE_W > DATA_W) begin : g_bad_fit
      $error("control code fields do not fit the payload");
   end

   for (genvar i = 0; i < LANE_CNT; i++) begin : g_lane
      logic [CODE_W-1:0] code;
      assign code = pld_i[LANE_W + CODE_W*i +: CODE_W];
      always_comb begin
         if (code == CODE_W'(CC_IDLE)) chars_o[i*LANE_W +: LANE_W] = LANE_W'(XC_IDLE);
         else                          chars_o[i*LANE_W +: LANE_W] = LANE_W'(XC_ERR);
      end
   end

endmodule

// File: rtl/dec66_omap.sv
module dec66_omap #(
   parameter int LANE_W = 8
) (
   input  logic [3:0]        ocode_i,
   output logic [LANE_W-1:0] char_o
);
   import dec66_pkg::*;

   always_comb begin
      case (ocode_i)
         OC_SEQ:  char_o = LANE_W'(XC_SEQ);
         OC_SIG:  char_o = LANE_W'(XC_SIG);
         default: char_o = LANE_W'(XC_ERR);
      endcase
   end

endmodule

// File: rtl/dec66_lanes.sv
module dec66_lanes #(
   parameter int LANE_CNT = 8,
   parameter int LANE_W   = 8,
   parameter int CODE_W   = 7,
   parameter int HDR_W    = 2,
   localparam int DATA_W  = LANE_CNT * LANE_W,
   localparam int HALF    = LANE_CNT / 2
) (
   input  logic [HDR_W-1:0]    hdr_i,
   input  logic [DATA_W-1:0]   pld_i,
   output logic [DATA_W-1:0]   data_o,
   output logic [LANE_CNT-1:0] ctrl_o
);
   import dec66_pkg::*;

   logic [DATA_W-1:0] cchars;
   logic [DATA_W-1:0] shifted;
   logic [LANE_W-1:0] os_lo;
   logic [LANE_W-1:0] os_hi;
   logic [LANE_W-1:0] btype;
   term_t             term;

   dec66_cmap #(.LANE_CNT(LANE_CNT), .LANE_W(LANE_W), .CODE_W(CODE_W)) u_cmap (
      .pld_i   (pld_i),
      .chars_o (cchars)
   );

   dec66_omap #(.LANE_W(LANE_W)) u_omap_lo (
      .ocode_i (pld_i[HALF*LANE_W +: 4]),
      .char_o  (os_lo)
   );

   dec66_omap #(.LANE_W(LANE_W)) u_omap_hi (
      .ocode_i (pld_i[HALF*LANE_W + 4 +: 4]),
      .char_o  (os_hi)
   );

   assign btype   = pld_i[LANE_W-1:0];
   assign shifted = pld_i >> LANE_W;
   assign term    = term_lookup(8'(btype));

   always_comb begin
      data_o = {LANE_CNT{LANE_W'(XC_ERR)}};
      ctrl_o = '1;
      if (hdr_i == HDR_W'(SH_DATA)) begin
         data_o = pld_i;
         ctrl_o = '0;
      end else if (hdr_i == HDR_W'(SH_CTRL)) begin
         if (term.hit) begin
            for (int i = 0; i < LANE_CNT; i++) begin
               if (i < int'(term.lane)) begin
                  data_o[i*LANE_W +: LANE_W] = shifted[i*LANE_W +: LANE_W];
                  ctrl_o[i] = 1'b0;
               end else if (i == int'(term.lane)) begin
                  data_o[i*LANE_W +: LANE_W] = LANE_W'(XC_TERM);
               end else begin
                  data_o[i*LANE_W +: LANE_W] = cchars[i*LANE_W +: LANE_W];
               end
            end
         end else begin
            case (8'(btype))
               BT_ALL_CTRL: begin
                  data_o = cchars;
               end
               BT_C_OS4, BT_C_ST4: begin
                  data_o = pld_i;
                  data_o[HALF*LANE_W-1:0] = cchars[HALF*LANE_W-1:0];
                  data_o[HALF*LANE_W +: LANE_W] =
                     (8'(btype) == BT_C_ST4) ? LANE_W'(XC_START) : os_hi;
                  ctrl_o = '0;
                  ctrl_o[HALF:0] = '1;
               end
               BT_OS_ST4, BT_OS_OS: begin
                  data_o = pld_i;
                  data_o[LANE_W-1:0] = os_lo;
                  data_o[HALF*LANE_W +: LANE_W] =
                     (8'(btype) == BT_OS_ST4) ? LANE_W'(XC_START) : os_hi;
                  ctrl_o = '0;
                  ctrl_o[0] = 1'b1;
                  ctrl_o[HALF] = 1'b1;
               end
               BT_ST0: begin
                  data_o = pld_i;
                  data_o[LANE_W-1:0] = LANE_W'(XC_START);
                  ctrl_o = '0;
                  ctrl_o[0] = 1'b1;
               end
               BT_OS_C: begin
                  data_o = cchars;
                  data_o[HALF*LANE_W-1:0] = pld_i[HALF*LANE_W-1:0];
                  data_o[LANE_W-1:0] = os_lo;
                  ctrl_o = '1;
                  ctrl_o[HALF-1:1] = '0;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dec66_xgmii_dec.sv
module dec66_xgmii_dec #(
   parameter int LANE_CNT = 8,
   parameter int LANE_W   = 8,
   parameter int CODE_W   = 7,
   parameter int HDR_W    = 2,
   localparam int DATA_W  = LANE_CNT * LANE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                blk_valid_i,
   input  logic [HDR_W-1:0]    blk_hdr_i,
   input  logic [DATA_W-1:0]   blk_pld_i,
   output logic [DATA_W-1:0]   xg_data_o,
   output logic [LANE_CNT-1:0] xg_ctrl_o,
   output logic                xg_valid_o
);
   import dec66_pkg::*;

   if (LANE_CNT != 8) begin : g_bad_lanes
      $error("lane count must be 8");
   end
   if (LANE_W != 8) begin : g_bad_width
      $error("lane width must be 8");
   end
   if (HDR_W != 2) begin : g_bad_hdr
      $error("header width must be 2");
   end

   logic [DATA_W-1:0]   dec_data;
   logic [LANE_CNT-1:0] dec_ctrl;

   dec66_lanes #(
      .LANE_CNT (LANE_CNT),
      .LANE_W   (LANE_W),
      .CODE_W   (CODE_W),
      .HDR_W    (HDR_W)
   ) u_lanes (
      .hdr_i  (blk_hdr_i),
      .pld_i  (blk_pld_i),
      .data_o (dec_data),
      .ctrl_o (dec_ctrl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xg_data_o  <= {LANE_CNT{LANE_W'(XC_IDLE)}};
         xg_ctrl_o  <= '1;
         xg_valid_o <= 1'b0;
      end else begin
         xg_valid_o <= blk_valid_i;
         if (blk_valid_i) begin
            xg_data_o <= dec_data;
            xg_ctrl_o <= dec_ctrl;
         end
      end
   end

endmodule

// File: rtl/dec66_xgmii_dec_chk.sv
module dec66_xgmii_dec_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        blk_valid_i,
   input logic [1:0]  blk_hdr_i,
   input logic [63:0] blk_pld_i,
   input logic [63:0] xg_data_o,
   input logic [7:0]  xg_ctrl_o,
   input logic        xg_valid_o
);

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> xg_valid_o == $past(blk_valid_i)); // R10

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_valid_i |=> $stable(xg_data_o) && $stable(xg_ctrl_o)); // R10

   AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid_i && blk_hdr_i == 2'b01 |=>
         xg_ctrl_o == 8'h00 && xg_data_o == $past(blk_pld_i)); // R1

   AST_BAD_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid_i && (blk_hdr_i == 2'b00 || blk_hdr_i == 2'b11) |=>
         xg_ctrl_o == 8'hFF && xg_data_o == {8{8'hFE}}); // R8

   AST_START0: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid_i && blk_hdr_i == 2'b10 && blk_pld_i[7:0] == 8'h78 |=>
         xg_ctrl_o == 8'h01 && xg_data_o[7:0] == 8'hFB); // R3

   AST_TERM0: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid_i && blk_hdr_i == 2'b10 && blk_pld_i[7:0] == 8'h87 |=>
         xg_ctrl_o == 8'hFF && xg_data_o[7:0] == 8'hFD); // R7

endmodule

bind dec66_xgmii_dec dec66_xgmii_dec_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .blk_valid_i (blk_valid_i),
   .blk_hdr_i   (blk_hdr_i),
   .blk_pld_i   (blk_pld_i),
   .xg_data_o   (xg_data_o),
   .xg_ctrl_o   (xg_ctrl_o),
   .xg_valid_o  (xg_valid_o)
);

// File: tb/dec66_xgmii_dec_bench.sv
`timescale 1ns/1ps
module dec66_xgmii_dec_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_valid_i = 1'b0;
   logic [1:0]  blk_hdr_i = 2'b00;
   logic [63:0] blk_pld_i = '0;
   logic [63:0] xg_data_o;
   logic [7:0]  xg_ctrl_o;
   logic        xg_valid_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   dec66_xgmii_dec u_dec66_xgmii_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .blk_valid_i (blk_valid_i),
      .blk_hdr_i   (blk_hdr_i),
      .blk_pld_i   (blk_pld_i),
      .xg_data_o   (xg_data_o),
      .xg_ctrl_o   (xg_ctrl_o),
      .xg_valid_o  (xg_valid_o)
   );

   function automatic logic [7:0] ref_code(input logic [63:0] p, input int lane);
      logic [6:0] c;
      c = p[8 + 7*lane +: 7];
      return (c == 7'h00) ? 8'h07 : 8'hFE;
   endfunction

   function automatic logic [7:0] ref_os(input logic [3:0] n);
      if (n == 4'h0) return 8'h9C;
      if (n == 4'hF) return 8'h5C;
      return 8'hFE;
   endfunction

   function automatic logic [71:0] ref_dec(input logic [1:0] h, input logic [63:0] p);
      logic [7:0] b [8];
      logic [7:0] d [8];
      logic [7:0] c;
      int tl;
      for (int i = 0; i < 8; i++) begin
         b[i] = p[8*i +: 8];
         d[i] = 8'hFE;
      end
      c = 8'hFF;
      if (h == 2'b01) begin
         for (int i = 0; i < 8; i++) d[i] = b[i];
         c = 8'h00;
      end else if (h == 2'b10) begin
         tl = -1;
         case (b[0])
            8'h87: tl = 0; 8'h99: tl = 1; 8'hAA: tl = 2; 8'hB4: tl = 3;
            8'hCC: tl = 4; 8'hD2: tl = 5; 8'hE1: tl = 6; 8'hFF: tl = 7;
            default: tl = -1;
         endcase
         if (tl >= 0) begin
            for (int i = 0; i < 8; i++) begin
               if (i < tl) begin d[i] = b[i+1]; c[i] = 1'b0; end
               else if (i == tl) d[i] = 8'hFD;
               else d[i] = ref_code(p, i);
            end
         end else begin
            case (b[0])
               8'h1E: for (int i = 0; i < 8; i++) d[i] = ref_code(p, i);
               8'h2D, 8'h33: begin
                  for (int i = 0; i < 4; i++) d[i] = ref_code(p, i);
                  d[4] = (b[0] == 8'h33) ? 8'hFB : ref_os(b[4][7:4]);
                  for (int i = 5; i < 8; i++) d[i] = b[i];
                  c = 8'h1F;
               end
               8'h66, 8'h55: begin
                  d[0] = ref_os(b[4][3:0]);
                  d[4] = (b[0] == 8'h66) ? 8'hFB : ref_os(b[4][7:4]);
                  for (int i = 1; i < 4; i++) d[i] = b[i];
                  for (int i = 5; i < 8; i++) d[i] = b[i];
                  c = 8'h11;
               end
               8'h78: begin
                  d[0] = 8'hFB;
                  for (int i = 1; i < 8; i++) d[i] = b[i];
                  c = 8'h01;
               end
               8'h4B: begin
                  d[0] = ref_os(b[4][3:0]);
                  for (int i = 1; i < 4; i++) d[i] = b[i];
                  for (int i = 4; i < 8; i++) d[i] = ref_code(p, i);
                  c = 8'hF1;
               end
               default: c = 8'hFF;
            endcase
         end
      end
      return {c, d[7], d[6], d[5], d[4], d[3], d[2], d[1], d[0]};
   endfunction

   function automatic string req_of(input logic [1:0] h, input logic [7:0] bt);
      if (h == 2'b01) return "R1";
      if (h != 2'b10) return "R8";
      case (bt)
         8'h1E: return "R2";
         8'h78: return "R3";
         8'h33: return "R4";
         8'h4B, 8'h2D: return "R5";
         8'h66, 8'h55: return "R6";
         8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string r, input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] h, input logic [63:0] p);
      @(negedge clk);
      blk_valid_i = 1'b1;
      blk_hdr_i   = h;
      blk_pld_i   = p;
      @(negedge clk);
      chk(req_of(h, p[7:0]), {xg_ctrl_o, xg_data_o}, ref_dec(h, p));
   endtask

   function automatic logic [63:0] put_code(input logic [63:0] p, input int lane, input logic [6:0] c);
      logic [63:0] q;
      q = p;
      q[8 + 7*lane +: 7] = c;
      return q;
   endfunction

   initial begin
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [63:0] p;
      logic [71:0] held;
      logic [7:0]  bts [16];
      void'($urandom(32'h5EED_0042));
      bts = '{8'h1E, 8'h2D, 8'h33, 8'h66, 8'h55, 8'h78, 8'h4B, 8'h87,
              8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF, 8'h00};

      repeat (3) @(negedge clk);
      chk("R11", {xg_valid_o, xg_ctrl_o, xg_data_o}, {1'b0, 8'hFF, {8{8'h07}}});
      rst_n = 1'b1;

      send(2'b01, 64'h0123_4567_89AB_CDEF);                                    // R1
      chk("R10", {71'd0, xg_valid_o}, 72'd1);                                  // R10 valid follows
      send(2'b10, 64'h0000_0000_0000_001E);                                    // R2 all idle
      p = put_code(64'h1E, 3, 7'h1E); p = put_code(p, 5, 7'h2D);
      send(2'b10, p);                                                          // R2 mixed codes
      send(2'b10, 64'hDDCC_BBAA_9988_7778);                                    // R3
      send(2'b10, 64'h3322_1100_0000_0033);                                    // R4
      send(2'b10, 64'h0000_0000_F0EE_DD4B);                                    // R5 O=0
      send(2'b10, 64'h1111_1105_0000_004B);                                    // R5 O=5 error
      send(2'b10, 64'h7766_55F0_0000_002D);                                    // R5 O=F at lane 4
      send(2'b10, 64'hABCD_EFF0_1234_5666);                                    // R6 0x66
      send(2'b10, 64'hABCD_EF0F_1234_5655);                                    // R6 0x55
      foreach (bts[k]) if (k >= 7 && k <= 14)
         send(2'b10, {56'h0807_0605_0403_02, bts[k]} & 64'h0000_0000_00FF_FFFF |
                     (64'h0 | bts[k]));                                         // R7 low codes idle
      send(2'b10, 64'hFFFF_FFFF_FFFF_FF87);                                    // R7 codes all error
      send(2'b10, 64'h0706_0504_0302_01E1);                                    // R7 lane 6
      send(2'b00, 64'h0000_0000_0000_001E);                                    // R8
      send(2'b11, 64'h1234_5678_9ABC_DEF0);                                    // R8
      send(2'b10, 64'h0000_0000_0000_0012);                                    // R9

      held = {xg_ctrl_o, xg_data_o};
      @(negedge clk);
      blk_valid_i = 1'b0;
      blk_hdr_i   = 2'b01;
      blk_pld_i   = 64'hDEAD_BEEF_0BAD_F00D;
      @(negedge clk);
      chk("R10", {xg_ctrl_o, xg_data_o}, held);                                // R10 hold
      chk("R10", {71'd0, xg_valid_o}, 72'd0);
      @(negedge clk);
      chk("R10", {xg_ctrl_o, xg_data_o}, held);

      for (int n = 0; n < 400; n++) begin
         int r;
         logic [1:0] h;
         r = int'($urandom_range(0, 99));
         h = (r < 80) ? 2'b10 : (r < 95) ? 2'b01 : 2'($urandom);
         p = {$urandom, $urandom};
         p[7:0] = bts[$urandom_range(0, 15)];
         if (p[7:0] == 8'h00) p[7:0] = 8'($urandom);
         for (int l = 0; l < 8; l++) begin
            int s;
            s = int'($urandom_range(0, 2));
            if (s == 0) p = put_code(p, l, 7'h00);
            else if (s == 1) p = put_code(p, l, 7'h1E);
         end
         if ($urandom_range(0, 1) == 1) p[35:32] = 4'h0;
         if ($urandom_range(0, 1) == 1) p[39:36] = 4'hF;
         send(h, p);
      end

      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule